// File: doc/BRIEF.md
# Pulse-Coded Isolation Channel Link

This block is a cycle-level model of one channel of a logic isolator whose two sides talk through a coupling element that carries only short pulses. A sending half turns every change of the input level into a single one-cycle pulse. It uses a "set" line for rising changes and a "clear" line for falling ones. While the input stays still, it repeats the present level as a refresh pulse at a fixed spacing, so a receiver that missed an edge or started late still settles on the right level.

The receiving half keeps a two-state latch that the pulses drive high or low. It also runs a silence timer that pulls the output low once no pulse has arrived for a set number of cycles. A transmit-enable input models power loss on the sending side. Dropping it silences both pulse lines, so the timeout path can be exercised. All timing is counted in clock cycles through the parameters REFRESH_CYCLES and WDOG_CYCLES. The silence limit is intended to be four times the refresh spacing, so a live sender never trips the timer.

The two pulse lines are brought out as ports so the traffic between the halves can be observed directly.

Top module: `pulse_iso_link`

## Requirements
- R1: A rising change of din, sampled at clock edge k, raises link_set for exactly one cycle, registered at edge k+2 (two synchronizer flops plus the pulse register), with link_clr low in that cycle.
- R2: A falling change of din, sampled at edge k, raises link_clr for exactly one cycle, registered at edge k+2, with link_set low in that cycle.
- R3: link_set and link_clr are never high in the same cycle.
- R4: dout goes to 1 at the edge after link_set is high and to 0 at the edge after link_clr is high; with pulses arriving, dout equals the din value sampled three edges earlier.
- R5: After any pulse, if din stays unchanged, a refresh pulse follows exactly REFRESH_CYCLES edges later and again at every further REFRESH_CYCLES edges: link_set when the synchronized level is 1, link_clr when it is 0. An edge pulse restarts this spacing.
- R6: After reset is released with din held at 0, the first pulse is a refresh on link_clr, registered at the REFRESH_CYCLES-th edge.
- R7: While tx_enable is low, neither pulse line is raised; changes of din in that time leave dout unchanged.
- R8: If the last pulse is high in cycle n and no pulse follows, dout is forced to 0 at edge n+1+WDOG_CYCLES and is still unchanged at the edge before.
- R9: After a timeout, the next pulse drives dout again at once: with tx_enable raised and din rising together, dout is 1 four edges later.
- R10: While rst is high, dout, link_set and link_clr are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both halves |
| rst | input | 1 | Synchronous active-high reset |
| tx_enable | input | 1 | Sending side powered; low silences the pulse lines |
| din | input | 1 | Input logic level, asynchronous to clk |
| dout | output | 1 | Rebuilt output level |
| link_set | output | 1 | One-cycle pulse: level went or stays high |
| link_clr | output | 1 | One-cycle pulse: level went or stays low |

## Verification
A wrong edge detector or synchronizer shows up as a pulse in the wrong cycle or on the wrong line. The latched output then lags or leads the input by other than three cycles, which the bench sees within four cycles of any input change. A refresh counter that restarts at the wrong point moves the idle pulses off their fixed spacing and is exposed in the first idle interval. A silence timer that counts wrongly or is not cleared by a pulse makes dout drop one cycle early or late after the sender goes quiet, or drop while pulses still flow.

// File: rtl/pulse_iso_pkg.sv
package pulse_iso_pkg;

    // One coupling-element transfer: at most one line high per cycle.
    typedef struct packed {
        logic set;
        logic clr;
    } pulse_t;

    // The receive-side bistable.
    typedef enum logic {
        LAT_LOW  = 1'b0,
        LAT_HIGH = 1'b1
    } latch_t;

    // Why the encoder fires in a given cycle.
    typedef enum logic [1:0] {
        SRC_NONE    = 2'd0,
        SRC_EDGE    = 2'd1,
        SRC_REFRESH = 2'd2,
        SRC_MUTED   = 2'd3
    } pulse_src_t;

    localparam pulse_t PULSE_IDLE = '{set: 1'b0, clr: 1'b0};

    // Pulse that reports a level (used for both edges and refresh).
    function automatic pulse_t level_pulse(input logic level);
        pulse_t p;
        p.set = level;
        p.clr = ~level;
        return p;
    endfunction

    function automatic logic any_pulse(input pulse_t p);
        return p.set | p.clr;
    endfunction

    // Next bistable state from an incoming pulse.
    function automatic latch_t latch_next(input latch_t cur, input pulse_t p);
        latch_t n;
        n = cur;
        if (p.set)
            n = LAT_HIGH;
        else if (p.clr)
            n = LAT_LOW;
        return n;
    endfunction

endpackage

// File: rtl/pulse_iso_sync.sv
module pulse_iso_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst)
                        chain[0] <= 1'b0;
                    else
                        chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst)
                        chain[i] <= 1'b0;
                    else
                        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/pulse_iso_enc.sv
module pulse_iso_enc
    import pulse_iso_pkg::*;
#(
    parameter int REFRESH_CYCLES = 16,
    parameter int SYNC_STAGES    = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   en,
    input  logic   din,
    output pulse_t tx
);
    localparam int CW = $clog2(REFRESH_CYCLES + 1);
    localparam logic [CW-1:0] REF_LAST = CW'(REFRESH_CYCLES - 1);

    logic          lvl;
    logic          lvl_d;
    logic [CW-1:0] ref_cnt;
    logic [CW-1:0] ref_cnt_nxt;
    pulse_t        tx_q;
    pulse_t        tx_nxt;
    pulse_src_t    src;
    logic          changed;
    logic          ref_due;

    pulse_iso_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (din),
        .q   (lvl)
    );

    assign changed = lvl ^ lvl_d;
    assign ref_due = (ref_cnt == REF_LAST);

    // Priority: power loss, then a real change, then the idle refresh.
    always_comb begin
        if (!en)
            src = SRC_MUTED;
        else if (changed)
            src = SRC_EDGE;
        else if (ref_due)
            src = SRC_REFRESH;
        else
            src = SRC_NONE;
    end

    always_comb begin
        unique case (src)
            SRC_EDGE, SRC_REFRESH: begin
                tx_nxt      = level_pulse(lvl);
                ref_cnt_nxt = '0;
            end
            SRC_MUTED: begin
                tx_nxt      = PULSE_IDLE;
                ref_cnt_nxt = '0;
            end
            default: begin
                tx_nxt      = PULSE_IDLE;
                ref_cnt_nxt = ref_cnt + CW'(1);
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_d   <= 1'b0;
            ref_cnt <= '0;
            tx_q    <= PULSE_IDLE;
        end else begin
            lvl_d   <= lvl;
            ref_cnt <= ref_cnt_nxt;
            tx_q    <= tx_nxt;
        end
    end

    assign tx = tx_q;

    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(tx_q.set && tx_q.clr)); // R3
    AST_SET_NARROW: assert property (@(posedge clk) disable iff (rst)
        tx_q.set |=> !tx_q.set); // R1
    AST_CLR_NARROW: assert property (@(posedge clk) disable iff (rst)
        tx_q.clr |=> !tx_q.clr); // R2
    AST_MUTED_SILENT: assert property (@(posedge clk) disable iff (rst)
        !$past(en) |-> !(tx_q.set || tx_q.clr)); // R7
    AST_REF_RANGE: assert property (@(posedge clk) disable iff (rst)
        ref_cnt < CW'(REFRESH_CYCLES)); // R5
    AST_EDGE_SENDS: assert property (@(posedge clk) disable iff (rst)
        (en && changed) |=> (tx_q.set == $past(lvl)) && (tx_q.clr == !$past(lvl))); // R1

endmodule

// File: rtl/pulse_iso_wdog.sv
module pulse_iso_wdog #(
    parameter int WDOG_CYCLES = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic kick,
    output logic expire
);
    localparam int CW = $clog2(WDOG_CYCLES + 1);
    localparam logic [CW-1:0] WD_LAST = CW'(WDOG_CYCLES - 1);

    logic [CW-1:0] quiet;

    // Counts pulse-free edges since the last pulse; saturates at the limit.
    always_ff @(posedge clk) begin
        if (rst)
            quiet <= '0;
        else if (kick)
            quiet <= '0;
        else if (quiet != WD_LAST)
            quiet <= quiet + CW'(1);
    end

    assign expire = (quiet == WD_LAST);

    AST_WD_CLEARED: assert property (@(posedge clk) disable iff (rst)
        kick |=> (quiet == '0)); // R8
    AST_WD_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (!kick && !expire) |=> (quiet == $past(quiet) + CW'(1))); // R8
    AST_WD_BOUND: assert property (@(posedge clk) disable iff (rst)
        quiet <= WD_LAST); // R8

endmodule

// File: rtl/pulse_iso_dec.sv
module pulse_iso_dec
    import pulse_iso_pkg::*;
#(
    parameter int WDOG_CYCLES = 64
) (
    input  logic   clk,
    input  logic   rst,
    input  pulse_t rx,
    output logic   dout
);
    latch_t state;
    latch_t state_nxt;
    logic   kick;
    logic   expire;

    assign kick = any_pulse(rx);

    pulse_iso_wdog #(.WDOG_CYCLES(WDOG_CYCLES)) u_wdog (
        .clk    (clk),
        .rst    (rst),
        .kick   (kick),
        .expire (expire)
    );

    // A pulse always wins over the timeout, so recovery is immediate.
    always_comb begin
        if (kick)
            state_nxt = latch_next(state, rx);
        else if (expire)
            state_nxt = LAT_LOW;
        else
            state_nxt = state;
    end

    always_ff @(posedge clk) begin
        if (rst)
            state <= LAT_LOW;
        else
            state <= state_nxt;
    end

    assign dout = (state == LAT_HIGH);

    AST_SET_HIGH: assert property (@(posedge clk) disable iff (rst)
        rx.set |=> dout); // R4
    AST_CLR_LOW: assert property (@(posedge clk) disable iff (rst)
        rx.clr |=> !dout); // R4
    AST_TIMEOUT_LOW: assert property (@(posedge clk) disable iff (rst)
        (expire && !kick) |=> !dout); // R8
    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!kick && !expire) |=> $stable(dout)); // R4

endmodule

// File: rtl/pulse_iso_link.sv
module pulse_iso_link
    import pulse_iso_pkg::*;
#(
    parameter int REFRESH_CYCLES = 16,
    parameter int WDOG_CYCLES    = 64,
    parameter int SYNC_STAGES    = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tx_enable,
    input  logic din,
    output logic dout,
    output logic link_set,
    output logic link_clr
);
    pulse_t wire_pulse;

    pulse_iso_enc #(
        .REFRESH_CYCLES (REFRESH_CYCLES),
        .SYNC_STAGES    (SYNC_STAGES)
    ) u_enc (
        .clk (clk),
        .rst (rst),
        .en  (tx_enable),
        .din (din),
        .tx  (wire_pulse)
    );

    pulse_iso_dec #(
        .WDOG_CYCLES (WDOG_CYCLES)
    ) u_dec (
        .clk  (clk),
        .rst  (rst),
        .rx   (wire_pulse),
        .dout (dout)
    );

    assign link_set = wire_pulse.set;
    assign link_clr = wire_pulse.clr;

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> !(link_set || link_clr || dout)); // R10
    AST_LINK_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(link_set && link_clr)); // R3

endmodule

// File: tb/pulse_iso_link_test.sv
module pulse_iso_link_test;
    localparam int R = 8;
    localparam int W = 32;

    logic clk = 1'b0;
    logic rst;
    logic tx_enable;
    logic din;
    logic dout;
    logic link_set;
    logic link_clr;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int last_pulse = 0;
    int base;
    logic [63:0] hist;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pulse_iso_link #(.REFRESH_CYCLES(R), .WDOG_CYCLES(W), .SYNC_STAGES(2)) uut (
        .clk       (clk),
        .rst       (rst),
        .tx_enable (tx_enable),
        .din       (din),
        .dout      (dout),
        .link_set  (link_set),
        .link_clr  (link_clr)
    );

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    task automatic step();
        @(negedge clk);
        cyc++;
        if (link_set || link_clr)
            last_pulse = cyc;
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s cycle %0d actual %0d expected %0d", tag, cyc, act, exp);
        end
    endtask

    task automatic chk_pulse(input string tag, input logic es, input logic ec);
        chk(link_set == es, {tag, " link_set"}, int'(link_set), int'(es));
        chk(link_clr == ec, {tag, " link_clr"}, int'(link_clr), int'(ec));
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        tx_enable = 1'b1;
        din = 1'b0;
        repeat (3) step();
        // R10: quiet while in reset
        chk(dout == 1'b0, "R10 dout", int'(dout), 0);
        chk_pulse("R10", 1'b0, 1'b0);

        rst = 1'b0;
        cyc = 0;
        // R6: first refresh on link_clr at edge R
        for (int i = 1; i < R; i++) begin
            step();
            chk_pulse("R6 before refresh", 1'b0, 1'b0);
        end
        step();
        chk_pulse("R6 first refresh", 1'b0, 1'b1);

        // R1: rising change
        din = 1'b1;
        base = cyc;
        step();
        step();
        chk_pulse("R1 early", 1'b0, 1'b0);
        step();
        chk_pulse("R1 pulse", 1'b1, 1'b0);
        chk(dout == 1'b0, "R4 latency", int'(dout), 0);
        step();
        chk_pulse("R1 narrow", 1'b0, 1'b0);
        chk(dout == 1'b1, "R4 follows set", int'(dout), 1);

        // R5: refresh spacing while idle high
        base = base + 3;
        while (cyc < base + 3 * R) begin
            step();
            if ((cyc - base) % R == 0)
                chk_pulse("R5 refresh high", 1'b1, 1'b0);
            else
                chk_pulse("R5 idle gap", 1'b0, 1'b0);
        end
        chk(dout == 1'b1, "R5 dout held", int'(dout), 1);

        // R2: falling change, then refresh on link_clr
        din = 1'b0;
        base = cyc;
        step();
        step();
        chk_pulse("R2 early", 1'b0, 1'b0);
        step();
        chk_pulse("R2 pulse", 1'b0, 1'b1);
        step();
        chk_pulse("R2 narrow", 1'b0, 1'b0);
        chk(dout == 1'b0, "R4 follows clr", int'(dout), 0);
        base = base + 3;
        while (cyc < base + R) begin
            step();
            if (cyc == base + R)
                chk_pulse("R5 refresh low", 1'b0, 1'b1);
            else
                chk_pulse("R5 gap low", 1'b0, 1'b0);
        end

        // Sweep of every 8-bit pattern, one bit per cycle
        hist = '0;
        for (int p = 0; p < 256; p++) begin
            for (int b = 7; b >= 0; b--) begin
                din = p[b];
                hist[cyc & 63] = din;
                step();
                chk(dout == hist[(cyc - 4) & 63], "R4 sweep latency",
                    int'(dout), int'(hist[(cyc - 4) & 63]));
                if (hist[(cyc - 3) & 63] != hist[(cyc - 4) & 63])
                    chk_pulse("R1 R2 sweep edge", hist[(cyc - 3) & 63], !hist[(cyc - 3) & 63]);
                chk(!(link_set && link_clr), "R3 exclusive", int'(link_set & link_clr), 0);
            end
        end

        din = 1'b1;
        repeat (2 * R) step();
        chk(dout == 1'b1, "R4 settle high", int'(dout), 1);

        // R7 / R8: sender silenced, din wiggles, timeout drops dout
        tx_enable = 1'b0;
        base = cyc;
        while (cyc < last_pulse + W) begin
            step();
            if (cyc % 3 == 0)
                din = ~din;
            chk_pulse("R7 silent", 1'b0, 1'b0);
            chk(dout == 1'b1, "R7 dout unchanged", int'(dout), 1);
        end
        step();
        chk(dout == 1'b0, "R8 timeout low", int'(dout), 0);
        din = 1'b0;
        repeat (6) begin
            step();
            chk_pulse("R7 still silent", 1'b0, 1'b0);
            chk(dout == 1'b0, "R8 stays low", int'(dout), 0);
        end

        // R9: recovery on the next pulse
        tx_enable = 1'b1;
        din = 1'b1;
        repeat (3) step();
        chk_pulse("R9 pulse", 1'b1, 1'b0);
        step();
        chk(dout == 1'b1, "R9 restored", int'(dout), 1);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule